// File: doc/BRIEF.md
# Bulk-Clear Line State Store

This block holds a three-bit coherence state for every line of a cache and lets the surrounding cache controller read and write one line's state at a time. It also changes the state of every line together, in a fixed number of cycles that does not depend on the line count or on how many lines are in speculative states. Three bulk commands are supported: open a speculative region, close it successfully, and abandon it. A command is written as one or more array-wide primitives. The first primitive clears a chosen bit in every word. The second clears a chosen bit only in the words where another chosen bit is set.

A small sequencer turns each command into its primitives and applies one primitive per clock. It raises a busy flag while a command is in progress, and single-line writes are refused while the flag is high. A command that arrives while the sequencer is busy waits in a one-entry holding slot and starts on the clock edge where the current command finishes.

Top module: `spec_state_array`

## Requirements
- R1: Line states are coded with bit 2 as the speculative marker: I=000, S=001, M=010, XP=100, US=101, UM=110. A write with `wrEn` high while `busy` is low stores `wrState` into line `wrIdx` at the clock edge. `rdState` shows the stored state of line `rdIdx` combinationally.
- R2: The open command (`cmdCode`=01) clears bit 2 of every line: XP becomes I, US becomes S, UM becomes M, and I, S and M are unchanged. `busy` is high for exactly one cycle.
- R3: The close command (`cmdCode`=10) uses the same single primitive as R2, with the same per-state result and one busy cycle.
- R4: The abandon command (`cmdCode`=11) applies, on three successive edges and in this order: clear bit 1 where bit 2 is set, clear bit 0 where bit 2 is set, clear bit 2 everywhere. XP, US and UM all end as I, and I, S and M are unchanged. `busy` is high for exactly three cycles.
- R5: How long a command stays busy depends only on the command. It does not change with how many lines hold speculative states, including the case where every line does.
- R6: A line write requested while `busy` is high is dropped and leaves the line unchanged.
- R7: A command accepted while busy is held in a one-entry slot and starts on the edge where the current command ends, with no idle cycle in between. `cmdReady` is low while the slot is full, and a command presented while `cmdReady` is low is ignored.
- R8: `cmdCode`=00 with `cmdValid` high is not a command. It does not raise `busy` and leaves every line unchanged.
- R9: After reset every line reads I, `busy` is low and `cmdReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A bulk command is presented |
| cmdCode | input | 2 | 01 open, 10 close, 11 abandon, 00 none |
| cmdReady | output | 1 | The holding slot can take a command |
| busy | output | 1 | A bulk command is in progress |
| wrEn | input | 1 | Single-line state write request |
| wrIdx | input | IDX_W | Line to write |
| wrState | input | 3 | State to write |
| rdIdx | input | IDX_W | Line to read |
| rdState | output | 3 | State of line `rdIdx` |

## Verification
Several properties are checked on every cycle. A clear-everywhere primitive leaves no line with the target bit set on the next cycle. A line write never coincides with a bulk primitive. At most one primitive is active at a time, and the masked clear of bit 0 is always followed by the plain clear of bit 2. The holding slot is only ever full while busy, and busy only ends after a plain clear. The per-state results of each command, the exact busy lengths, the ordering of a queued command and dropped writes or commands can only be shown by the bench's scenarios, which compare read-back states and counted busy cycles against values taken from the requirements.

// File: rtl/spec_state_pkg.sv
package spec_state_pkg;

  localparam int STATE_W = 3;
  localparam int SPEC_BIT = 2;

  typedef logic [STATE_W-1:0] lineState_t;

  localparam lineState_t ST_I  = 3'b000;
  localparam lineState_t ST_S  = 3'b001;
  localparam lineState_t ST_M  = 3'b010;
  localparam lineState_t ST_XP = 3'b100;
  localparam lineState_t ST_US = 3'b101;
  localparam lineState_t ST_UM = 3'b110;

  typedef enum logic [1:0] {
    CMD_NONE     = 2'b00,
    CMD_OPEN     = 2'b01,
    CMD_CLOSE    = 2'b10,
    CMD_ABANDON  = 2'b11
  } bulkCmd_t;

  // strobes from the sequencer to the storage
  typedef struct packed {
    logic       clrAll;     // clear tgtBit in every word
    logic       clrMasked;  // clear tgtBit where mskBit is set
    logic [1:0] tgtBit;
    logic [1:0] mskBit;
  } bulkStrobe_t;

endpackage

// File: rtl/state_store.sv
module state_store
  import spec_state_pkg::*;
#(
  parameter int LINES = 64,
  parameter int IDX_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  bulkStrobe_t strobe,
  input  logic        wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  lineState_t  wrState,
  input  logic [IDX_W-1:0] rdIdx,
  output lineState_t  rdState
);

  lineState_t words [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        words[g] <= ST_I;
      end else if (strobe.clrAll) begin
        words[g][strobe.tgtBit] <= 1'b0;
      end else if (strobe.clrMasked) begin
        if (words[g][strobe.mskBit]) words[g][strobe.tgtBit] <= 1'b0;
      end else if (wrEn && (wrIdx == IDX_W'(g))) begin
        words[g] <= wrState;
      end
    end
  end

  assign rdState = words[rdIdx];

  // column-wise OR: is any line holding each bit
  logic [STATE_W-1:0] colAny;
  always_comb begin
    colAny = '0;
    for (int i = 0; i < LINES; i++) colAny = colAny | words[i];
  end

  AST_BULK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clrAll |=> !colAny[$past(strobe.tgtBit)]) else $error("bulk clear left a bit set"); // R2

  AST_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrEn && (strobe.clrAll || strobe.clrMasked))) else $error("write during bulk step"); // R6

endmodule

// File: rtl/bulk_sequencer.sv
module bulk_sequencer
  import spec_state_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdValid,
  input  bulkCmd_t    cmdCode,
  output logic        cmdReady,
  output logic        busy,
  output bulkStrobe_t strobe
);

  localparam int STEP_W = 2;
  localparam logic [STEP_W-1:0] ABANDON_LAST = 2'd2;

  logic             active;
  bulkCmd_t         curCmd;
  logic [STEP_W-1:0] step;
  logic             slotFull;
  bulkCmd_t         slotCmd;

  logic cmdLive, accept, lastStep;

  assign cmdReady = !slotFull;
  assign cmdLive  = cmdValid && (cmdCode != CMD_NONE);
  assign accept   = cmdLive && cmdReady;
  assign lastStep = active && ((curCmd != CMD_ABANDON) || (step == ABANDON_LAST));
  assign busy     = active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      curCmd   <= CMD_NONE;
      step     <= '0;
      slotFull <= 1'b0;
      slotCmd  <= CMD_NONE;
    end else if (!active) begin
      if (accept) begin
        active <= 1'b1;
        curCmd <= cmdCode;
        step   <= '0;
      end
    end else if (lastStep) begin
      step <= '0;
      if (slotFull) begin
        curCmd   <= slotCmd;
        slotFull <= 1'b0;
      end else if (accept) begin
        curCmd <= cmdCode;
      end else begin
        active <= 1'b0;
      end
    end else begin
      step <= step + 1'b1;
      if (accept) begin
        slotFull <= 1'b1;
        slotCmd  <= cmdCode;
      end
    end
  end

  always_comb begin
    strobe = '0;
    if (active) begin
      if (curCmd == CMD_ABANDON && step == 2'd0) begin
        strobe.clrMasked = 1'b1;
        strobe.mskBit    = 2'(SPEC_BIT);
        strobe.tgtBit    = 2'd1;
      end else if (curCmd == CMD_ABANDON && step == 2'd1) begin
        strobe.clrMasked = 1'b1;
        strobe.mskBit    = 2'(SPEC_BIT);
        strobe.tgtBit    = 2'd0;
      end else begin
        strobe.clrAll = 1'b1;
        strobe.tgtBit = 2'(SPEC_BIT);
      end
    end
  end

  AST_SLOT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    slotFull |-> active) else $error("slot full while idle"); // R7

  AST_ONE_PRIMITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.clrAll, strobe.clrMasked})) else $error("two primitives at once"); // R4

  AST_ABANDON_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.clrMasked && strobe.tgtBit == 2'd0) |=> strobe.clrAll) else $error("plain clear missing after masks"); // R4

  AST_BUSY_ENDS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active) |-> $past(strobe.clrAll)) else $error("busy ended without final clear"); // R5

endmodule

// File: rtl/spec_state_array.sv
module spec_state_array
  import spec_state_pkg::*;
#(
  parameter  int LINES = 64,
  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmdValid,
  input  logic [1:0]       cmdCode,
  output logic             cmdReady,
  output logic             busy,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [2:0]       wrState,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [2:0]       rdState
);

  bulkStrobe_t strobe;
  logic        wrGated;

  assign wrGated = wrEn && !busy;

  bulk_sequencer seq_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmdValid (cmdValid),
    .cmdCode  (bulkCmd_t'(cmdCode)),
    .cmdReady (cmdReady),
    .busy     (busy),
    .strobe   (strobe)
  );

  state_store #(.LINES(LINES), .IDX_W(IDX_W)) store_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .wrEn    (wrGated),
    .wrIdx   (wrIdx),
    .wrState (wrState),
    .rdIdx   (rdIdx),
    .rdState (rdState)
  );

  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cmdReady) else $error("not ready while idle"); // R9

endmodule

// File: tb/spec_state_array_tb.sv
module spec_state_array_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LINES = 64;
  localparam int NVEC = 18;

  // {initial state, command, expected state}
  localparam logic [7:0] VEC [NVEC] = '{
    {3'b000, 2'b01, 3'b000}, {3'b001, 2'b01, 3'b001}, {3'b010, 2'b01, 3'b010},
    {3'b100, 2'b01, 3'b000}, {3'b101, 2'b01, 3'b001}, {3'b110, 2'b01, 3'b010},
    {3'b000, 2'b10, 3'b000}, {3'b001, 2'b10, 3'b001}, {3'b010, 2'b10, 3'b010},
    {3'b100, 2'b10, 3'b000}, {3'b101, 2'b10, 3'b001}, {3'b110, 2'b10, 3'b010},
    {3'b000, 2'b11, 3'b000}, {3'b001, 2'b11, 3'b001}, {3'b010, 2'b11, 3'b010},
    {3'b100, 2'b11, 3'b000}, {3'b101, 2'b11, 3'b000}, {3'b110, 2'b11, 3'b000}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmdValid = 1'b0;
  logic [1:0] cmdCode = 2'b00;
  logic       cmdReady, busy;
  logic       wrEn = 1'b0;
  logic [5:0] wrIdx = '0;
  logic [2:0] wrState = '0;
  logic [5:0] rdIdx = '0;
  logic [2:0] rdState;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_state_array #(.LINES(LINES)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdReady(cmdReady), .busy(busy), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrState(wrState), .rdIdx(rdIdx), .rdState(rdState)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic writeLine(input int idx, input logic [2:0] st);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 6'(idx); wrState = st;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readLine(input int idx, output int st);
    rdIdx = 6'(idx);
    #1;
    st = int'(rdState);
  endtask

  task automatic issueCmd(input logic [1:0] code, output int cycles);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = code;
    @(negedge clk);
    cmdValid = 1'b0; cmdCode = 2'b00;
    cycles = 0;
    while (busy && cycles < 20) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    int st, cyc, bad, bcnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 busy", int'(busy), 0);
    check("R9 ready", int'(cmdReady), 1);
    bad = 0;
    for (int i = 0; i < LINES; i++) begin readLine(i, st); if (st != 0) bad++; end
    check("R9 all lines I", bad, 0);

    // R1 write/read of each code
    writeLine(40, 3'b101);
    readLine(40, st);
    check("R1 write US", st, 5);
    writeLine(41, 3'b010);
    readLine(41, st);
    check("R1 write M", st, 2);

    // R2 R3 R4 table walk
    for (int v = 0; v < NVEC; v++) begin
      writeLine(v, VEC[v][7:5]);
      issueCmd(VEC[v][4:3], cyc);
      readLine(v, st);
      if (VEC[v][4:3] == 2'b01) begin
        check("R2 open result", st, int'(VEC[v][2:0]));
        check("R2 open busy", cyc, 1);
      end else if (VEC[v][4:3] == 2'b10) begin
        check("R3 close result", st, int'(VEC[v][2:0]));
        check("R3 close busy", cyc, 1);
      end else begin
        check("R4 abandon result", st, int'(VEC[v][2:0]));
        check("R4 abandon busy", cyc, 3);
      end
    end

    // R8 code 00 ignored
    writeLine(3, 3'b100);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = 2'b00;
    @(negedge clk);
    cmdValid = 1'b0;
    check("R8 no busy", int'(busy), 0);
    readLine(3, st);
    check("R8 line kept", st, 4);

    // R5 every line speculative
    for (int i = 0; i < LINES; i++) writeLine(i, 3'b110);
    issueCmd(2'b11, cyc);
    check("R5 abandon busy full array", cyc, 3);
    bad = 0;
    for (int i = 0; i < LINES; i++) begin readLine(i, st); if (st != 0) bad++; end
    check("R5 all lines I", bad, 0);
    for (int i = 0; i < LINES; i++) writeLine(i, 3'b100);
    issueCmd(2'b01, cyc);
    check("R5 open busy full array", cyc, 1);

    // R6 R7 queued command, dropped write, dropped command
    writeLine(10, 3'b010);
    writeLine(11, 3'b101);
    @(negedge clk);
    cmdValid = 1'b1; cmdCode = 2'b11;
    @(negedge clk);                         // busy: abandon in progress
    bcnt = busy ? 1 : 0;
    cmdCode = 2'b10;                        // close goes to the slot
    wrEn = 1'b1; wrIdx = 6'd10; wrState = 3'b001;
    @(negedge clk);
    bcnt += busy ? 1 : 0;
    check("R7 ready low when slot full", int'(cmdReady), 0);
    cmdCode = 2'b11;                        // must be ignored
    @(negedge clk);
    cmdValid = 1'b0; cmdCode = 2'b00; wrEn = 1'b0;
    while (busy && bcnt < 20) begin bcnt++; @(negedge clk); end
    check("R7 queued close runs back to back", bcnt, 4);
    check("R7 ready after drain", int'(cmdReady), 1);
    readLine(10, st);
    check("R6 write while busy dropped", st, 2);
    readLine(11, st);
    check("R4 US cleared by abandon", st, 0);

    finished = 1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule